// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block turns local read and write requests into single-cycle DRAM commands on a command/address bus. Each request names a bank, a row, a starting column, a burst-chop choice and an auto-precharge choice. The sequencer keeps an open-row record for each of eight banks. From that record it decides how to reach the column access. If the bank already holds the requested row, it issues the column command directly. If the bank is closed, it activates the row first. If the bank holds a different row, it precharges, activates and then issues the column command.

Commands use active-low RAS, CAS and WE strobes, a 3-bit bank field and a 16-bit address field, and a NOP fills every idle cycle. Each bank has its own countdown timer. The timer holds back a column command until the activate-to-column delay has passed, and holds back an activate until the precharge-to-activate delay has passed. The user-side ready signal stays low from the moment a request is accepted until its column command goes out, so only one request is in flight at a time. The burst length bit follows the request when per-command selection is enabled, and follows a fixed configured value otherwise.

Top module: `dram_cmd_seq`

## Requirements
- R1: During and directly after reset the bus shows NOP, bank and address are zero, `req_ready_o` is high and all banks count as closed.
- R2: {RAS,CAS,WE} encodes NOP=111, ACTIVATE=011, READ=101, WRITE=100, PRECHARGE=010, and NOP appears on every cycle that carries no scheduled command.
- R3: A request to a closed bank issues ACTIVATE with the row on the address field and the bank on the bank field, and then its column command to that bank.
- R4: A request whose row matches the row open in its bank issues only the column command, with no PRECHARGE and no ACTIVATE.
- R5: A request to a bank holding a different row issues PRECHARGE to that bank with address bit 10 at 0, then ACTIVATE, then the column command.
- R6: A column command carries the column on address bits [9:0], the auto-precharge flag on bit 10, and zero on bits 11 and 15:13. READ is issued for `req_write_i`=0 and WRITE for 1.
- R7: Address bit 12 of a column command is the inverse of `req_bc4_i` when `cfg_otf_i`=1 (0 = chop to 4, 1 = length 8), and equals `cfg_bl8_i` when `cfg_otf_i`=0.
- R8: A column command with auto-precharge closes its bank. The next request to that bank starts with ACTIVATE, even for the same row, and issues no PRECHARGE.
- R9: A column command comes no earlier than max(`cfg_trcd_i`,1) cycles after the ACTIVATE to its bank, and exactly then when that delay is the only thing holding it back.
- R10: An ACTIVATE comes no earlier than max(`cfg_trp_i`,1) cycles after the last PRECHARGE or auto-precharge column command to its bank, and exactly then when that delay is the only thing holding it back.
- R11: The first command of an accepted request appears on the second cycle after the accepting edge. Each later command needed by the request follows at the earliest cycle its timer allows. `req_ready_o` is low from the accepting edge until the cycle in which the column command appears, where it is high again.
- R12: Each bank keeps its own open row, so requests to other banks do not change whether a later request to it is a row hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer can take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | 3 | Target bank |
| req_row_i | input | 16 | Target row |
| req_col_i | input | 10 | Starting column of the burst |
| req_bc4_i | input | 1 | 1 = burst chop to 4 |
| req_ap_i | input | 1 | 1 = auto-precharge after the burst |
| cfg_otf_i | input | 1 | 1 = burst length chosen per command |
| cfg_bl8_i | input | 1 | Fixed value of address bit 12 when per-command choice is off |
| cfg_trcd_i | input | 4 | Activate-to-column delay in cycles |
| cfg_trp_i | input | 4 | Precharge-to-activate delay in cycles |
| cmd_ras_n_o | output | 1 | Row strobe, active low |
| cmd_cas_n_o | output | 1 | Column strobe, active low |
| cmd_we_n_o | output | 1 | Write enable, active low |
| cmd_ba_o | output | 3 | Bank field |
| cmd_addr_o | output | 16 | Address field |

## Verification
The bench mixes row hits, row conflicts and auto-precharge reuse of the same row, choosing rows from a small set so that all three cases occur often. A design that lost track of one bank when another was used would add needless ACTIVATEs, or would skip a PRECHARGE and activate over a live row. A design that ignored auto-precharge would treat the reuse as a hit. Timer delays of 0, small values and 7 expose off-by-one errors, which show up as a command one cycle early or late against a cycle-exact model. Both settings of the per-command burst length choice are run, so a design that used the wrong source for address bit 12 gives the wrong bit on column commands.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_WR  = 3'b100,
    CMD_PRE = 3'b010
  } cmd_e;

  localparam int unsigned AP_BIT = 10;
  localparam int unsigned BL_BIT = 12;
endpackage

// File: rtl/dram_bank_table.sv
module dram_bank_table
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 16,
  parameter int TMR_W     = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_e             upd_cmd_i,
  input  logic [BA_W-1:0]  upd_bank_i,
  input  logic [ROW_W-1:0] upd_row_i,
  input  logic             upd_ap_i,
  input  logic [TMR_W-1:0] trcd_i,
  input  logic [TMR_W-1:0] trp_i,
  input  logic [BA_W-1:0]  q_bank_i,
  output logic             q_open_o,
  output logic [ROW_W-1:0] q_row_o,
  output logic             q_tmr_zero_o
);
  logic             open_q [NUM_BANKS];
  logic [ROW_W-1:0] row_q  [NUM_BANKS];
  logic [TMR_W-1:0] tmr_q  [NUM_BANKS];
  logic [TMR_W-1:0] ld_rcd, ld_rp;

  // timer loaded with delay-1: zero means the next decision may use the bank
  assign ld_rcd = (trcd_i == '0) ? '0 : trcd_i - 1'b1;
  assign ld_rp  = (trp_i  == '0) ? '0 : trp_i  - 1'b1;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (upd_bank_i == BA_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
        tmr_q[b]  <= '0;
      end else begin
        if (tmr_q[b] != '0) tmr_q[b] <= tmr_q[b] - 1'b1;
        if (hit) begin
          unique case (upd_cmd_i)
            CMD_ACT: begin
              open_q[b] <= 1'b1;
              row_q[b]  <= upd_row_i;
              tmr_q[b]  <= ld_rcd;
            end
            CMD_PRE: begin
              open_q[b] <= 1'b0;
              tmr_q[b]  <= ld_rp;
            end
            CMD_RD, CMD_WR: begin
              if (upd_ap_i) begin
                open_q[b] <= 1'b0;
                tmr_q[b]  <= ld_rp;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign q_open_o     = open_q[q_bank_i];
  assign q_row_o      = row_q[q_bank_i];
  assign q_tmr_zero_o = (tmr_q[q_bank_i] == '0);
endmodule

// File: rtl/dram_cmd_pick.sv
module dram_cmd_pick
  import dram_seq_pkg::*;
(
  input  logic busy_i,
  input  logic write_i,
  input  logic open_i,
  input  logic hit_i,
  input  logic tmr_zero_i,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (busy_i) begin
      if (open_i && hit_i) begin
        if (tmr_zero_i) cmd_o = write_i ? CMD_WR : CMD_RD;
      end else if (open_i) begin
        cmd_o = CMD_PRE;
      end else if (tmr_zero_i) begin
        cmd_o = CMD_ACT;
      end
    end
  end
endmodule

// File: rtl/dram_cmd_encode.sv
module dram_cmd_encode
  import dram_seq_pkg::*;
#(
  parameter int BA_W   = 3,
  parameter int ADDR_W = 16,
  parameter int COL_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [BA_W-1:0]   bank_i,
  input  logic [ADDR_W-1:0] row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  input  logic              bl8_i,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_d;
  logic [BA_W-1:0]   ba_d;

  always_comb begin
    addr_d = '0;
    ba_d   = bank_i;
    unique case (cmd_i)
      CMD_ACT: addr_d = row_i;
      CMD_RD, CMD_WR: begin
        addr_d[COL_W-1:0] = col_i;
        addr_d[AP_BIT]    = ap_i;
        addr_d[BL_BIT]    = bl8_i;
      end
      CMD_PRE: ;
      default: ba_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {ras_n_o, cas_n_o, we_n_o} <= 3'b111;
      ba_o   <= '0;
      addr_o <= '0;
    end else begin
      {ras_n_o, cas_n_o, we_n_o} <= cmd_i;
      ba_o   <= ba_d;
      addr_o <= addr_d;
    end
  end
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 16,
  parameter int COL_W     = 10,
  parameter int TMR_W     = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BA_W-1:0]   req_bank_i,
  input  logic [ADDR_W-1:0] req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_bc4_i,
  input  logic              req_ap_i,
  input  logic              cfg_otf_i,
  input  logic              cfg_bl8_i,
  input  logic [TMR_W-1:0]  cfg_trcd_i,
  input  logic [TMR_W-1:0]  cfg_trp_i,
  output logic              cmd_ras_n_o,
  output logic              cmd_cas_n_o,
  output logic              cmd_we_n_o,
  output logic [BA_W-1:0]   cmd_ba_o,
  output logic [ADDR_W-1:0] cmd_addr_o
);
  logic              busy_q;
  logic              wr_q, bc4_q, ap_q;
  logic [BA_W-1:0]   bank_q;
  logic [ADDR_W-1:0] row_q;
  logic [COL_W-1:0]  col_q;

  logic              b_open, b_tmr_zero, row_hit, col_issue, bl8;
  logic [ADDR_W-1:0] b_row;
  cmd_e              next_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      bc4_q  <= 1'b0;
      ap_q   <= 1'b0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else if (!busy_q) begin
      if (req_valid_i) begin
        busy_q <= 1'b1;
        wr_q   <= req_write_i;
        bc4_q  <= req_bc4_i;
        ap_q   <= req_ap_i;
        bank_q <= req_bank_i;
        row_q  <= req_row_i;
        col_q  <= req_col_i;
      end
    end else if (col_issue) begin
      busy_q <= 1'b0;
    end
  end

  assign req_ready_o = !busy_q;

  dram_bank_table #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ADDR_W), .TMR_W(TMR_W)
  ) u_banks (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_cmd_i   (next_cmd),
    .upd_bank_i  (bank_q),
    .upd_row_i   (row_q),
    .upd_ap_i    (ap_q),
    .trcd_i      (cfg_trcd_i),
    .trp_i       (cfg_trp_i),
    .q_bank_i    (bank_q),
    .q_open_o    (b_open),
    .q_row_o     (b_row),
    .q_tmr_zero_o(b_tmr_zero)
  );

  assign row_hit = (b_row == row_q);

  dram_cmd_pick u_pick (
    .busy_i    (busy_q),
    .write_i   (wr_q),
    .open_i    (b_open),
    .hit_i     (row_hit),
    .tmr_zero_i(b_tmr_zero),
    .cmd_o     (next_cmd)
  );

  assign col_issue = (next_cmd == CMD_RD) || (next_cmd == CMD_WR);
  assign bl8       = cfg_otf_i ? ~bc4_q : cfg_bl8_i;

  dram_cmd_encode #(
    .BA_W(BA_W), .ADDR_W(ADDR_W), .COL_W(COL_W)
  ) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (next_cmd),
    .bank_i (bank_q),
    .row_i  (row_q),
    .col_i  (col_q),
    .ap_i   (ap_q),
    .bl8_i  (bl8),
    .ras_n_o(cmd_ras_n_o),
    .cas_n_o(cmd_cas_n_o),
    .we_n_o (cmd_we_n_o),
    .ba_o   (cmd_ba_o),
    .addr_o (cmd_addr_o)
  );
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 16,
  parameter int TMR_W     = 4,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int CNT_W    = TMR_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic [TMR_W-1:0]  cfg_trcd_i,
  input logic [TMR_W-1:0]  cfg_trp_i,
  input logic              cmd_ras_n_o,
  input logic              cmd_cas_n_o,
  input logic              cmd_we_n_o,
  input logic [BA_W-1:0]   cmd_ba_o,
  input logic [ADDR_W-1:0] cmd_addr_o
);
  logic [2:0] c;
  logic is_act, is_pre, is_col;
  logic [CNT_W-1:0] eff_rcd, eff_rp;
  logic             sh_open   [NUM_BANKS];
  logic [CNT_W-1:0] since_act [NUM_BANKS];
  logic [CNT_W-1:0] since_cls [NUM_BANKS];

  assign c      = {cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o};
  assign is_act = (c == 3'b011);
  assign is_pre = (c == 3'b010);
  assign is_col = (c == 3'b101) || (c == 3'b100);
  assign eff_rcd = (cfg_trcd_i == '0) ? CNT_W'(1) : CNT_W'(cfg_trcd_i);
  assign eff_rp  = (cfg_trp_i  == '0) ? CNT_W'(1) : CNT_W'(cfg_trp_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sh
    logic sel;
    assign sel = (cmd_ba_o == BA_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_open[b]   <= 1'b0;
        since_act[b] <= '1;
        since_cls[b] <= '1;
      end else begin
        if (since_act[b] != '1) since_act[b] <= since_act[b] + 1'b1;
        if (since_cls[b] != '1) since_cls[b] <= since_cls[b] + 1'b1;
        if (sel && is_act) begin
          sh_open[b]   <= 1'b1;
          since_act[b] <= CNT_W'(1);
        end
        if (sel && (is_pre || (is_col && cmd_addr_o[10]))) begin
          sh_open[b]   <= 1'b0;
          since_cls[b] <= CNT_W'(1);
        end
      end
    end
  end

  AST_LEGAL_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c == 3'b111) || is_act || is_pre || is_col); // R2
  AST_COL_NEEDS_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> sh_open[cmd_ba_o]); // R3
  AST_ACT_ON_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> !sh_open[cmd_ba_o]); // R5
  AST_PRE_ONE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> (!cmd_addr_o[10] && sh_open[cmd_ba_o])); // R5
  AST_RCD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> (since_act[cmd_ba_o] >= eff_rcd)); // R9
  AST_RP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> (since_cls[cmd_ba_o] >= eff_rp)); // R10
  AST_BUSY_ON_ROW_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act || is_pre) |-> !req_ready_o); // R11
  AST_READY_AFTER_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> req_ready_o); // R11
endmodule

bind dram_cmd_seq dram_seq_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .TMR_W(TMR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .cfg_trcd_i (cfg_trcd_i),
  .cfg_trp_i  (cfg_trp_i),
  .cmd_ras_n_o(cmd_ras_n_o),
  .cmd_cas_n_o(cmd_cas_n_o),
  .cmd_we_n_o (cmd_we_n_o),
  .cmd_ba_o   (cmd_ba_o),
  .cmd_addr_o (cmd_addr_o)
);

// File: tb/tb_dram_cmd_seq.sv
module tb_dram_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, ready;
  logic        wr = 1'b0, bc4 = 1'b0, ap = 1'b0;
  logic [2:0]  bank = '0;
  logic [15:0] row = '0;
  logic [9:0]  col = '0;
  logic        otf = 1'b1, bl8f = 1'b1;
  logic [3:0]  trcd = 4'd3, trp = 4'd2;
  logic        ras_n, cas_n, we_n;
  logic [2:0]  ba;
  logic [15:0] addr;

  always #2 clk = ~clk; // 250 MHz

  dram_cmd_seq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_ready_o(ready),
    .req_write_i(wr), .req_bank_i(bank), .req_row_i(row), .req_col_i(col),
    .req_bc4_i(bc4), .req_ap_i(ap),
    .cfg_otf_i(otf), .cfg_bl8_i(bl8f), .cfg_trcd_i(trcd), .cfg_trp_i(trp),
    .cmd_ras_n_o(ras_n), .cmd_cas_n_o(cas_n), .cmd_we_n_o(we_n),
    .cmd_ba_o(ba), .cmd_addr_o(addr)
  );

  typedef struct {
    int          t;
    logic [2:0]  c;
    logic [2:0]  b;
    logic [15:0] a;
    int          tag;
    logic        is_col;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_chk = 0, n_bad = 0;
  bit   mon_on = 1'b0, done = 1'b0;

  // bench model of bank state
  bit          m_open [8];
  logic [15:0] m_row  [8];
  int          m_act  [8];
  int          m_cls  [8];
  int          last_bank = -1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int eff(input logic [3:0] v);
    return (v == 4'd0) ? 1 : int'(v);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input bit ok, input int tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s at cycle %0d: actual=%h expected=%h", tag, what, cyc, act, expv);
    end
  endtask

  // monitor: every cycle compare bus with the model's schedule (R2, R11)
  always @(negedge clk) begin
    if (mon_on && !done) begin
      logic [2:0] c;
      c = {ras_n, cas_n, we_n};
      if (exp_q.size() > 0 && exp_q[0].t == cyc) begin
        check({c, ba, addr} == {exp_q[0].c, exp_q[0].b, exp_q[0].a}, exp_q[0].tag,
              "command", {9'd0, c, ba, addr}, {9'd0, exp_q[0].c, exp_q[0].b, exp_q[0].a});
        if (exp_q[0].is_col) // R7 burst length bit
          check(addr[12] == exp_q[0].a[12], 7, "A12", {31'd0, addr[12]}, {31'd0, exp_q[0].a[12]});
        void'(exp_q.pop_front());
      end else begin
        check(c == 3'b111, 2, "idle NOP", {29'd0, c}, 32'd7); // R2
      end
      check(ready == (exp_q.size() == 0), 11, "ready", {31'd0, ready},
            {31'd0, exp_q.size() == 0}); // R11
    end
  end

  function automatic void push(input int t, input logic [2:0] c, input logic [2:0] b,
                               input logic [15:0] a, input int tag, input logic is_col);
    exp_t e;
    e.t = t; e.c = c; e.b = b; e.a = a; e.tag = tag; e.is_col = is_col;
    exp_q.push_back(e);
  endfunction

  // schedule for a request accepted at the edge starting cycle n0
  function automatic void model(input int n0, input logic w, input logic [2:0] bk,
                                input logic [15:0] r, input logic [9:0] cl,
                                input logic b4, input logic apf);
    int t, ta, tc, ctag;
    logic [15:0] ca;
    logic a12;
    t = n0 + 1; // R11 first command two cycles after acceptance
    if (m_open[bk] && m_row[bk] == r) begin
      ctag = (last_bank != int'(bk)) ? 12 : 4; // R4 hit, R12 other banks untouched
    end else begin
      if (m_open[bk]) begin
        push(t, 3'b010, bk, 16'h0000, 5, 1'b0); // R5 precharge first
        m_cls[bk] = t;
        t++;
        m_open[bk] = 1'b0;
      end
      ta = imax(t, m_cls[bk] + eff(trp));
      // R10 when held back by precharge timer, R8 after auto-precharge, else R3
      push(ta, 3'b011, bk, r, (ta > t) ? 10 : ((m_cls[bk] > -1000) ? 8 : 3), 1'b0);
      m_act[bk] = ta; m_open[bk] = 1'b1; m_row[bk] = r;
      t = ta + 1;
      ctag = 6;
    end
    tc = imax(t, m_act[bk] + eff(trcd));
    if (tc > t) ctag = 9; // R9 column waited on activate timer
    a12 = otf ? ~b4 : bl8f;
    ca = {3'b000, a12, 1'b0, apf, cl}; // R6 layout
    push(tc, w ? 3'b100 : 3'b101, bk, ca, ctag, 1'b1);
    if (apf) begin
      m_open[bk] = 1'b0;
      m_cls[bk] = tc;
    end
    last_bank = int'(bk);
  endfunction

  task automatic send(input logic w, input logic [2:0] bk, input logic [15:0] r,
                      input logic [9:0] cl, input logic b4, input logic apf);
    @(negedge clk); #1;
    wr = w; bank = bk; row = r; col = cl; bc4 = b4; ap = apf; valid = 1'b1;
    while (!ready) begin
      @(negedge clk); #1;
    end
    model(cyc + 1, w, bk, r, cl, b4, apf);
    @(negedge clk); #1;
    valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic rand_run(input int n);
    logic [15:0] rows [3];
    rows[0] = 16'h0000; rows[1] = 16'h1234; rows[2] = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      send(1'($urandom), 3'($urandom % 8), rows[$urandom % 3], 10'($urandom),
           1'($urandom), ($urandom % 4) == 0);
      if (($urandom % 4) == 0) repeat ($urandom % 5) @(negedge clk);
    end
    drain();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < 8; b++) begin
      m_open[b] = 1'b0; m_row[b] = '0; m_act[b] = -1000; m_cls[b] = -1000;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check({ras_n, cas_n, we_n} == 3'b111, 1, "reset cmd", {29'd0, ras_n, cas_n, we_n}, 32'd7);
    check(ba == 3'd0 && addr == 16'd0, 1, "reset ba/addr", {13'd0, ba, addr}, 32'd0);
    check(ready == 1'b1, 1, "reset ready", {31'd0, ready}, 32'd1);
    @(negedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check({ras_n, cas_n, we_n} == 3'b111, 1, "post-reset cmd", {29'd0, ras_n, cas_n, we_n}, 32'd7);
    mon_on = 1'b1;

    // directed: closed bank (R3), hit (R4), conflict (R5), edge fields (R6)
    send(1'b0, 3'd1, 16'h00AA, 10'h005, 1'b0, 1'b0);
    send(1'b1, 3'd1, 16'h00AA, 10'h3FF, 1'b1, 1'b0);
    send(1'b0, 3'd1, 16'hFFFF, 10'h000, 1'b0, 1'b0);
    // R12: other bank, then back to bank 1 same row
    send(1'b1, 3'd7, 16'h0001, 10'h123, 1'b0, 1'b0);
    send(1'b0, 3'd1, 16'hFFFF, 10'h200, 1'b1, 1'b0);
    // R8: auto-precharge, then same row again
    send(1'b1, 3'd7, 16'h0001, 10'h001, 1'b0, 1'b1);
    send(1'b0, 3'd7, 16'h0001, 10'h002, 1'b0, 1'b0);
    drain();
    rand_run(150);

    // fixed burst length 8, minimal delays (R7, R9, R10)
    otf = 1'b0; bl8f = 1'b1; trcd = 4'd0; trp = 4'd0;
    send(1'b0, 3'd2, 16'h0100, 10'h010, 1'b1, 1'b1);
    send(1'b0, 3'd2, 16'h0100, 10'h011, 1'b1, 1'b0);
    drain();
    rand_run(100);

    // fixed burst chop, long delays
    otf = 1'b0; bl8f = 1'b0; trcd = 4'd7; trp = 4'd5;
    send(1'b1, 3'd3, 16'h0300, 10'h030, 1'b0, 1'b0);
    send(1'b1, 3'd3, 16'h0301, 10'h031, 1'b0, 1'b1);
    send(1'b0, 3'd3, 16'h0301, 10'h032, 1'b1, 1'b0);
    drain();
    rand_run(100);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog expired: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule